// File: doc/BRIEF.md
# Guarded FIFO with Occupancy Count

This block is a single-clock first-in first-out buffer with 1024 entries by default. It guards itself against misuse. A push offered while the buffer is full is dropped inside the block, and a pop requested while it is empty is ignored. Each refused transfer sets a sticky error flag, so data loss is reported instead of corrupting the pointers or the occupancy count. The occupancy count has one more bit than the pointers, so it can report every value from zero up to the full depth.

The producer side is a valid/ready stream. A push takes effect in any cycle where `push_valid` and `push_ready` are both high. `push_ready` is high when the buffer has space, and also when the buffer is full and a pop is accepted in the same cycle. A producer that follows back-pressure never loses data. A producer that ignores it has the beat dropped at once (it is not held) and `ovf_flag` is raised.

The consumer raises `pop_ready` to take the oldest entry. The request is accepted when `pop_avail` is high. The entry then appears on `pop_data`, with `pop_valid` high, one cycle later. A programmable almost-full level drives a status output, and a registered copy of that output serves as an interrupt request line.

Top module: `gfifo_top`

## Requirements
- R1: After a synchronous active-low reset, count is 0, empty is 1, full is 0, both error flags are 0 and pop_valid is 0.
- R2: push_ready equals (count < DEPTH) or (pop_ready and count > 0). A push with push_valid and push_ready both high raises count by one, unless a pop is accepted in the same cycle.
- R3: count never exceeds DEPTH. A push offered while full, with no accepted pop, leaves the count and the stored contents unchanged.
- R4: A dropped push sets ovf_flag. The flag stays set until it is cleared.
- R5: An accepted pop (pop_ready high and count > 0) gives pop_valid high in the next cycle, with the oldest stored entry on pop_data. Entries leave in the order they were accepted.
- R6: A pop requested while empty changes nothing and sets the sticky udf_flag.
- R7: A push and a pop together while full are both accepted, and count stays at DEPTH.
- R8: A push and a pop together while empty: the push is accepted, the pop is refused, and udf_flag is set.
- R9: almost_full equals (count >= af_level), evaluated on the registered count.
- R10: irq_req is almost_full delayed by exactly one clock.
- R11: err_clr clears both flags at the next edge. An error in the same cycle as err_clr still sets its flag.
- R12: full is 1 exactly when count equals DEPTH, and empty is 1 exactly when count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| push_valid | input | 1 | Producer offers a beat |
| push_data | input | WIDTH | Producer beat |
| push_ready | output | 1 | Buffer can take the beat this cycle |
| pop_ready | input | 1 | Consumer requests the oldest entry |
| pop_avail | output | 1 | At least one entry is stored |
| pop_valid | output | 1 | pop_data holds a popped entry |
| pop_data | output | WIDTH | Popped entry, registered |
| af_level | input | CW | Almost-full threshold |
| err_clr | input | 1 | Clears both sticky error flags |
| count | output | CW | Occupancy, 0 to DEPTH |
| full | output | 1 | Buffer holds DEPTH entries |
| empty | output | 1 | Buffer holds no entries |
| almost_full | output | 1 | count >= af_level |
| irq_req | output | 1 | Registered almost-full interrupt request |
| ovf_flag | output | 1 | Sticky: a push was dropped |
| udf_flag | output | 1 | Sticky: a pop was refused |

## Verification
The bench fills the default 1024-entry buffer to the brim and keeps pushing. A design that does not gate writes would let the count pass 1024 or overwrite the oldest entry, and the order check on later pops would expose it. The bench also pushes and pops together on both the full boundary and the empty boundary. Wrong acceptance there would show as a count that drifts, a lost beat, or a missing or false underflow flag. A long pseudo-random phase changes the almost-full level and pulses the clear input, including in cycles that also carry an error. This catches off-by-one threshold compares, an interrupt that is not delayed by exactly one cycle, and clear logic that wins over a new error.

// File: rtl/gfifo_pkg.sv
package gfifo_pkg;
  typedef struct packed {
    logic push;
    logic pop;
  } xfer_t;
endpackage

// File: rtl/gfifo_ctrl.sv
module gfifo_ctrl
  import gfifo_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_valid,
  input  logic          pop_ready,
  output xfer_t         xfer,
  output logic          push_ready,
  output logic          pop_avail,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_C  = AW'(DEPTH - 1);

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST_C) ? '0 : p + AW'(1);
  endfunction

  assign full       = (count == DEPTH_C);
  assign empty      = (count == '0);
  assign pop_avail  = !empty;
  assign xfer.pop   = pop_ready && !empty;
  assign push_ready = !full || xfer.pop;
  assign xfer.push  = push_valid && push_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (xfer.push) wr_ptr <= bump(wr_ptr);
      if (xfer.pop)  rd_ptr <= bump(rd_ptr);
      case ({xfer.push, xfer.pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= DEPTH_C);
  assert_full_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop_ready) |=> (count == DEPTH_C) && $stable(wr_ptr));
  assert_full_both_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_valid && pop_ready) |=> (count == DEPTH_C));
  assert_empty_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !push_valid) |=> (count == '0) && $stable(rd_ptr));
endmodule

// File: rtl/gfifo_store.sv
module gfifo_store
  import gfifo_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  xfer_t            xfer,
  input  logic [AW-1:0]    wr_ptr,
  input  logic [AW-1:0]    rd_ptr,
  input  logic [WIDTH-1:0] push_data,
  output logic             pop_valid,
  output logic [WIDTH-1:0] pop_data
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (xfer.push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pop_valid <= 1'b0;
      pop_data  <= '0;
    end else begin
      pop_valid <= xfer.pop;
      if (xfer.pop) pop_data <= mem[rd_ptr];
    end
  end

  assert_pop_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer.pop |=> pop_valid);
  assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer.pop |=> !pop_valid);
endmodule

// File: rtl/gfifo_flags.sv
module gfifo_flags #(
  parameter int DEPTH = 1024,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_valid,
  input  logic          push_ready,
  input  logic          pop_ready,
  input  logic          empty,
  input  logic          err_clr,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] af_level,
  output logic          almost_full,
  output logic          irq_req,
  output logic          ovf_flag,
  output logic          udf_flag
);
  logic drop_push, drop_pop;

  assign drop_push   = push_valid && !push_ready;
  assign drop_pop    = pop_ready && empty;
  assign almost_full = (count >= af_level);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      udf_flag <= 1'b0;
      irq_req  <= 1'b0;
    end else begin
      ovf_flag <= drop_push || (ovf_flag && !err_clr);
      udf_flag <= drop_pop  || (udf_flag && !err_clr);
      irq_req  <= almost_full;
    end
  end

  assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !err_clr) |=> ovf_flag);
  assert_udf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (udf_flag && !err_clr) |=> udf_flag);
  assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !drop_push) |=> !ovf_flag);
  assert_irq_delay_R10: assert property (@(posedge clk) disable iff (!rst_n)
    almost_full |=> irq_req);
endmodule

// File: rtl/gfifo_top.sv
module gfifo_top
  import gfifo_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_valid,
  input  logic [WIDTH-1:0] push_data,
  output logic             push_ready,
  input  logic             pop_ready,
  output logic             pop_avail,
  output logic             pop_valid,
  output logic [WIDTH-1:0] pop_data,
  input  logic [CW-1:0]    af_level,
  input  logic             err_clr,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty,
  output logic             almost_full,
  output logic             irq_req,
  output logic             ovf_flag,
  output logic             udf_flag
);
  xfer_t         xfer;
  logic [AW-1:0] wr_ptr, rd_ptr;

  gfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .pop_ready(pop_ready),
    .xfer(xfer), .push_ready(push_ready), .pop_avail(pop_avail),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .count(count), .full(full), .empty(empty)
  );

  gfifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk(clk), .rst_n(rst_n), .xfer(xfer), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .push_data(push_data), .pop_valid(pop_valid), .pop_data(pop_data)
  );

  gfifo_flags #(.DEPTH(DEPTH)) u_flags (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_ready(push_ready),
    .pop_ready(pop_ready), .empty(empty), .err_clr(err_clr), .count(count),
    .af_level(af_level), .almost_full(almost_full), .irq_req(irq_req),
    .ovf_flag(ovf_flag), .udf_flag(udf_flag)
  );

  assert_flags_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
endmodule

// File: tb/gfifo_top_test.sv
`timescale 1ns/1ps
module gfifo_top_test;
  localparam int D  = 1024;
  localparam int W  = 16;
  localparam int CW = $clog2(D + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push_valid = 1'b0, pop_ready = 1'b0, err_clr = 1'b0;
  logic [W-1:0] push_data = '0;
  logic [CW-1:0] af_level = CW'(1000);
  logic push_ready, pop_avail, pop_valid, full, empty, almost_full, irq_req;
  logic ovf_flag, udf_flag;
  logic [W-1:0] pop_data;
  logic [CW-1:0] count;

  always #4 clk = ~clk;

  gfifo_top #(.DEPTH(D), .WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
    .push_ready(push_ready), .pop_ready(pop_ready), .pop_avail(pop_avail),
    .pop_valid(pop_valid), .pop_data(pop_data), .af_level(af_level),
    .err_clr(err_clr), .count(count), .full(full), .empty(empty),
    .almost_full(almost_full), .irq_req(irq_req), .ovf_flag(ovf_flag),
    .udf_flag(udf_flag)
  );

  int checks = 0, failures = 0;
  int m_cnt = 0, wseq = 0, rseq = 0;
  bit m_ovf = 0, m_udf = 0, m_irq = 0;
  bit done = 0;

  function automatic logic [W-1:0] pat(input int k);
    return W'(k * 29 + 3);
  endfunction

  task automatic chk(input longint act, input longint exp, input string req);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic step(input bit pv, input bit pr, input bit clr, input int thr);
    bit rd_ok, wr_ok;
    int vexp;
    push_valid = pv; pop_ready = pr; err_clr = clr; af_level = CW'(thr);
    push_data = pat(wseq);
    #1;
    chk(push_ready, (m_cnt < D) || (pr && m_cnt > 0), "R2 push_ready");
    chk(pop_avail, m_cnt > 0, "R5 pop_avail");
    rd_ok = pr && (m_cnt > 0);
    wr_ok = pv && ((m_cnt < D) || rd_ok);
    m_ovf = (pv && !wr_ok) || (m_ovf && !clr);  // R4 R11
    m_udf = (pr && m_cnt == 0) || (m_udf && !clr); // R6 R8 R11
    m_irq = (m_cnt >= thr);                      // R10
    vexp = rd_ok ? int'(pat(rseq)) : -1;
    if (rd_ok) rseq++;
    if (wr_ok) wseq++;
    m_cnt = m_cnt + int'(wr_ok) - int'(rd_ok);
    @(posedge clk); #1;
    chk(count, m_cnt, "R3 count");
    chk(full, m_cnt == D, "R12 full");
    chk(empty, m_cnt == 0, "R12 empty");
    chk(almost_full, m_cnt >= thr, "R9 almost_full");
    chk(irq_req, m_irq, "R10 irq_req");
    chk(ovf_flag, m_ovf, "R4 ovf_flag");
    chk(udf_flag, m_udf, "R6 udf_flag");
    chk(pop_valid, rd_ok, "R5 pop_valid");
    if (rd_ok) chk(pop_data, vexp, "R5 pop_data order");
    @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        failures++; checks++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    int thr = 1000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(count, 0, "R1 count");
    chk(empty, 1, "R1 empty");
    chk(full, 0, "R1 full");
    chk(ovf_flag, 0, "R1 ovf");
    chk(udf_flag, 0, "R1 udf");
    chk(pop_valid, 0, "R1 pop_valid");
    @(negedge clk);
    // R6: pop while empty
    step(0, 1, 0, thr);
    // R11: clear
    step(0, 0, 1, thr);
    // R8: push+pop while empty
    step(1, 1, 0, thr);
    step(0, 0, 1, thr);
    step(0, 1, 0, thr);
    // R2 R9: fill to full
    for (int i = 0; i < D; i++) step(1, 0, 0, thr);
    // R3 R4: pushes while full dropped
    for (int i = 0; i < 3; i++) step(1, 0, 0, thr);
    // R11: clear together with a new overflow -> stays set
    step(1, 0, 1, thr);
    step(0, 0, 1, thr);
    // R7: push+pop while full
    for (int i = 0; i < 4; i++) step(1, 1, 0, thr);
    // drain with threshold sweep, R5 order and R9/R10 edges
    for (int i = 0; i < D; i++) step(0, 1, 0, D - i);
    step(0, 1, 0, 0);
    step(0, 0, 1, 0);
    // pseudo-random mix
    for (int i = 0; i < 6000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[7:0] == 8'h5A) thr = int'(lfsr[15:6]) + 1;
      step(lfsr[0] | lfsr[3], lfsr[1] & (lfsr[4] | (i > 3000)),
           lfsr[9:2] == 8'h11, thr);
    end
    for (int i = 0; i < 4; i++) step(0, 1, 0, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule